// File: doc/BRIEF.md
# Word-Length Agnostic I2S Receiver

This block receives a Philips-style I2S stream as a slave: bit clock, word select and serial data all arrive from an outside transmitter. A faster system clock samples the three lines. Each word is turned into a fixed-width signed sample, 24 bits by default, and the left and right samples are presented together on parallel outputs with a one-cycle valid strobe.

The receiver never needs to know the transmitter's word length. The first bit after each word-select change is always the most significant bit. A word shorter than the sample width is padded with zeros in its low bits. Bits beyond the sample width are discarded. A 16-, 24- or 32-bit source therefore needs no configuration.

A ready flag reports a stable stream. The block also reports the frame period, measured in system clocks, which gives a direct reading of the sample rate.

Top module: `i2s_wordlen_rx`

## Requirements
- R1: After reset, `valid_o` and `ready_o` are 0, and `left_o`, `right_o` and `period_o` are all zero.
- R2: Bits are captured on the rising edge of the bit clock. A bit sampled together with a new word-select level is the last bit of the previous word. The bit on the next rising edge is the most significant bit of the new word.
- R3: Words captured while word select is low (0) appear on `left_o`. Words captured while it is high (1) appear on `right_o`.
- R4: A word of fewer than SAMPLE_W bits is placed from bit SAMPLE_W-1 downward, and every lower bit is zero. A 16-bit word w appears as w shifted left by 8.
- R5: A word of more than SAMPLE_W bits keeps only its first SAMPLE_W bits. A 32-bit word w appears as w shifted right by 8.
- R6: `valid_o` pulses for exactly one system clock per frame. The pulse comes once the most significant bit of the following left word has been sampled. `left_o` and `right_o` change only in that cycle. The first frame after reset is not presented, because its left word was not captured from its start.
- R7: The left and right words of a frame may differ in length. Each is aligned on its own.
- R8: `ready_o` rises after READY_FRAMES consecutive presented frames that are well formed. A frame is well formed when both words have the same length and that length is at least MIN_BITS. It rises in the cycle after the `valid_o` pulse of the last such frame.
- R9: A presented frame that is not well formed clears `ready_o` and restarts the count.
- R10: If word select stays at one level for IDLE_LIMIT system clocks, `ready_o` clears and word tracking restarts. The first complete frame after the stream resumes is presented.
- R11: `period_o` holds the number of system clocks between the last two `valid_o` pulses. For steady N-bit words with a bit clock of 2H system clocks, this is 4·N·H.
- R12: Decoding is correct for any bit clock at most one quarter of the system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock from the transmitter |
| ws_i | input | 1 | Word select, 0 = left, 1 = right |
| sd_i | input | 1 | Serial data, two's complement, MSB first |
| left_o | output | SAMPLE_W | Left sample of the last presented frame |
| right_o | output | SAMPLE_W | Right sample of the last presented frame |
| valid_o | output | 1 | One-cycle strobe, new sample pair |
| ready_o | output | 1 | Stream judged stable |
| period_o | output | PERIOD_W | System clocks per frame, last measurement |

## Verification
The bench builds the block with SYNC_STAGES=3, so the deeper synchroniser variant is in play, and with IDLE_LIMIT=400. That limit is longer than the longest word the bench sends, yet short enough that a stall can be reached in a few hundred clocks. The other parameters keep their defaults: SAMPLE_W=24, READY_FRAMES=2 and MIN_BITS=16. With these, 16-, 24- and 32-bit words exercise padding, exact fit and truncation. Bit clocks of one quarter and one sixth of the system clock reach the fastest and a slower ratio. A mixed-length frame and a stall drive the ready flag down and back up.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;
endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_i,
   input  logic ws_i,
   input  logic sd_i,
   output logic bit_stb_o,
   output logic ws_o,
   output logic sd_o,
   output logic ws_chg_o
);
   initial assert (STAGES >= 2) else $error("STAGES must be at least 2");

   logic [2:0] stage_q [STAGES];
   logic       bclk_q;
   logic       ws_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= {bclk_i, ws_i, sd_i};
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q <= 1'b0;
         ws_q   <= 1'b0;
      end else begin
         bclk_q <= stage_q[STAGES-1][2];
         ws_q   <= stage_q[STAGES-1][1];
      end
   end

   assign bit_stb_o = stage_q[STAGES-1][2] & ~bclk_q;
   assign ws_o      = stage_q[STAGES-1][1];
   assign sd_o      = stage_q[STAGES-1][0];
   assign ws_chg_o  = stage_q[STAGES-1][1] ^ ws_q;
endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
   import i2s_rx_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int CNT_W    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_stb_i,
   input  logic                ws_i,
   input  logic                sd_i,
   input  logic                resync_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic [CNT_W-1:0]    len_l_o,
   output logic [CNT_W-1:0]    len_r_o,
   output logic                pair_vld_o
);
   initial assert (SAMPLE_W >= 8) else $error("SAMPLE_W too small");
   initial assert ((1 << CNT_W) > SAMPLE_W) else $error("CNT_W too small");

   chan_e               ws_prev_q;
   chan_e               last_ch_q;
   logic                synced_q;
   logic                left_have_q;
   logic [SAMPLE_W-1:0] acc_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [SAMPLE_W-1:0] left_hold_q;
   logic [CNT_W-1:0]    len_hold_q;
   logic                boundary;

   // current bit belongs to the channel seen one bit clock earlier
   assign boundary = (ws_prev_q != last_ch_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ws_prev_q   <= CH_LEFT;
         last_ch_q   <= CH_LEFT;
         synced_q    <= 1'b0;
         left_have_q <= 1'b0;
         acc_q       <= '0;
         cnt_q       <= '0;
         left_hold_q <= '0;
         len_hold_q  <= '0;
         left_o      <= '0;
         right_o     <= '0;
         len_l_o     <= '0;
         len_r_o     <= '0;
         pair_vld_o  <= 1'b0;
      end else begin
         pair_vld_o <= 1'b0;
         if (resync_i) begin
            synced_q    <= 1'b0;
            left_have_q <= 1'b0;
         end else if (bit_stb_i) begin
            ws_prev_q <= chan_e'(ws_i);
            last_ch_q <= ws_prev_q;
            if (boundary) begin
               if (synced_q) begin
                  if (last_ch_q == CH_LEFT) begin
                     left_hold_q <= acc_q;
                     len_hold_q  <= cnt_q;
                     left_have_q <= 1'b1;
                  end else if (left_have_q) begin
                     left_o      <= left_hold_q;
                     right_o     <= acc_q;
                     len_l_o     <= len_hold_q;
                     len_r_o     <= cnt_q;
                     pair_vld_o  <= 1'b1;
                     left_have_q <= 1'b0;
                  end
               end
               synced_q <= 1'b1;
               acc_q    <= {sd_i, {(SAMPLE_W-1){1'b0}}};
               cnt_q    <= CNT_W'(1);
            end else begin
               for (int b = 0; b < SAMPLE_W; b++) begin
                  if (cnt_q == CNT_W'(SAMPLE_W-1-b)) acc_q[b] <= sd_i;
               end
               if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   AST_PAIR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      pair_vld_o |=> !pair_vld_o); // R6
   AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_vld_o |-> ($stable(left_o) && $stable(right_o))); // R6
   AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_vld_o && (int'(len_l_o) < SAMPLE_W)) |-> ((left_o << len_l_o) == '0)); // R4
endmodule

// File: rtl/i2s_rx_health.sv
module i2s_rx_health #(
   parameter int IDLE_LIMIT   = 512,
   parameter int READY_FRAMES = 2,
   parameter int MIN_BITS     = 16,
   parameter int CNT_W        = 6,
   parameter int PERIOD_W     = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ws_chg_i,
   input  logic                pair_vld_i,
   input  logic [CNT_W-1:0]    len_l_i,
   input  logic [CNT_W-1:0]    len_r_i,
   output logic                ready_o,
   output logic                resync_o,
   output logic [PERIOD_W-1:0] period_o
);
   localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);
   localparam int GOOD_W = $clog2(READY_FRAMES + 1);

   initial assert (IDLE_LIMIT >= 2) else $error("IDLE_LIMIT too small");
   initial assert (READY_FRAMES >= 1) else $error("READY_FRAMES must be positive");

   logic [IDLE_W-1:0]   idle_q;
   logic [GOOD_W-1:0]   good_q;
   logic [PERIOD_W-1:0] per_cnt_q;
   logic                frame_ok;

   assign resync_o = !ws_chg_i && (idle_q == IDLE_W'(IDLE_LIMIT - 1));
   assign frame_ok = (len_l_i == len_r_i) && (len_l_i >= CNT_W'(MIN_BITS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q    <= '0;
         good_q    <= '0;
         ready_o   <= 1'b0;
         per_cnt_q <= '0;
         period_o  <= '0;
      end else begin
         if (ws_chg_i)                          idle_q <= '0;
         else if (idle_q != IDLE_W'(IDLE_LIMIT)) idle_q <= idle_q + 1'b1;

         if (resync_o) begin
            ready_o <= 1'b0;
            good_q  <= '0;
         end else if (pair_vld_i) begin
            if (!frame_ok) begin
               ready_o <= 1'b0;
               good_q  <= '0;
            end else if (good_q >= GOOD_W'(READY_FRAMES - 1)) begin
               ready_o <= 1'b1;
            end else begin
               good_q <= good_q + 1'b1;
            end
         end

         if (pair_vld_i) begin
            period_o  <= per_cnt_q;
            per_cnt_q <= PERIOD_W'(1);
         end else if (per_cnt_q != '1) begin
            per_cnt_q <= per_cnt_q + 1'b1;
         end
      end
   end

   AST_READY_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> $past(pair_vld_i)); // R8
   AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      resync_o |=> !ready_o); // R10
endmodule

// File: rtl/i2s_wordlen_rx.sv
module i2s_wordlen_rx #(
   parameter int SAMPLE_W     = 24,
   parameter int MAX_BITS     = 32,
   parameter int SYNC_STAGES  = 2,
   parameter int IDLE_LIMIT   = 512,
   parameter int READY_FRAMES = 2,
   parameter int MIN_BITS     = 16,
   parameter int PERIOD_W     = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bclk_i,
   input  logic                ws_i,
   input  logic                sd_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o,
   output logic                ready_o,
   output logic [PERIOD_W-1:0] period_o
);
   localparam int CNT_W = $clog2(MAX_BITS + 1);

   initial assert (MAX_BITS >= SAMPLE_W) else $error("MAX_BITS below SAMPLE_W");

   logic             bit_stb;
   logic             ws_s;
   logic             sd_s;
   logic             ws_chg;
   logic             resync;
   logic [CNT_W-1:0] len_l;
   logic [CNT_W-1:0] len_r;

   i2s_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .bclk_i(bclk_i), .ws_i(ws_i), .sd_i(sd_i),
      .bit_stb_o(bit_stb), .ws_o(ws_s), .sd_o(sd_s), .ws_chg_o(ws_chg)
   );

   i2s_rx_deser #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) i_deser (
      .clk(clk), .rst_n(rst_n),
      .bit_stb_i(bit_stb), .ws_i(ws_s), .sd_i(sd_s), .resync_i(resync),
      .left_o(left_o), .right_o(right_o),
      .len_l_o(len_l), .len_r_o(len_r), .pair_vld_o(valid_o)
   );

   i2s_rx_health #(
      .IDLE_LIMIT(IDLE_LIMIT), .READY_FRAMES(READY_FRAMES),
      .MIN_BITS(MIN_BITS), .CNT_W(CNT_W), .PERIOD_W(PERIOD_W)
   ) i_health (
      .clk(clk), .rst_n(rst_n),
      .ws_chg_i(ws_chg), .pair_vld_i(valid_o),
      .len_l_i(len_l), .len_r_i(len_r),
      .ready_o(ready_o), .resync_o(resync), .period_o(period_o)
   );
endmodule

// File: tb/test_i2s_wordlen_rx.sv
module test_i2s_wordlen_rx;
   localparam int CLK_PERIOD = 10;
   localparam int SW = 24;
   localparam int PW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bclk = 1'b0;
   logic          ws = 1'b0;
   logic          sd = 1'b0;
   logic [SW-1:0] left_o, right_o;
   logic          valid_o, ready_o;
   logic [PW-1:0] period_o;

   int checks = 0;
   int errors = 0;
   int half = 2;
   bit done = 0;
   logic [2*SW-1:0] exp_q [$];
   string           tag_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   i2s_wordlen_rx #(.SYNC_STAGES(3), .IDLE_LIMIT(400)) i_i2s_wordlen_rx (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .ws_i(ws), .sd_i(sd),
      .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
      .ready_o(ready_o), .period_o(period_o)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [SW-1:0] align(input logic [31:0] v, input int n);
      if (n >= SW) return SW'(v >> (n - SW));
      return SW'(v << (SW - n));
   endfunction

   task automatic send_word(input logic [31:0] v, input int n, input logic own_ws, input logic next_ws);
      for (int i = n - 1; i >= 0; i--) begin
         bclk = 1'b0;
         sd   = v[i];
         ws   = (i == 0) ? next_ws : own_ws;
         repeat (half) @(negedge clk);
         bclk = 1'b1;
         repeat (half) @(negedge clk);
      end
   endtask

   task automatic send_frame(input logic [31:0] l, input int nl, input logic [31:0] r, input int nr,
                             input bit expect_it, input string tag);
      send_word(l, nl, 1'b0, 1'b1);
      send_word(r, nr, 1'b1, 1'b0);
      if (expect_it) begin
         exp_q.push_back({align(l, nl), align(r, nr)});
         tag_q.push_back(tag);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && valid_o) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected pair", {16'h0, left_o, right_o}, 64'h0);
         end else begin
            logic [2*SW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({left_o, right_o} == e, t, {16'h0, left_o, right_o}, {16'h0, e});
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(valid_o == 1'b0, "R1 valid", 64'(valid_o), 64'h0);
      check(ready_o == 1'b0, "R1 ready", 64'(ready_o), 64'h0);
      check(left_o == '0 && right_o == '0, "R1 samples", {16'h0, left_o, right_o}, 64'h0);
      check(period_o == '0, "R1 period", 64'(period_o), 64'h0);

      // first frame after reset is not presented (R6)
      send_frame(32'h00123456, 24, 32'h00ABCDEF, 24, 0, "");
      // R2 R3: exact 24-bit words, left/right by word select
      send_frame(32'h00800001, 24, 32'h007FFFFE, 24, 1, "R2 R3 24-bit pair");
      send_frame(32'h00A5A5A5, 24, 32'h005A5A5A, 24, 1, "R2 R3 24-bit pair");
      send_frame(32'h00FFFFFF, 24, 32'h00000001, 24, 1, "R2 R3 24-bit pair");
      check(ready_o == 1'b1, "R8 ready after two good frames", 64'(ready_o), 64'h1);
      check(period_o == PW'(4*24*2), "R11 period 24-bit", 64'(period_o), 64'(4*24*2));

      // R4: 16-bit words zero filled
      send_frame(32'h00008001, 16, 32'h00007FFF, 16, 1, "R4 16-bit zero fill");
      send_frame(32'h0000FFFF, 16, 32'h00001234, 16, 1, "R4 16-bit zero fill");
      send_frame(32'h0000C3C3, 16, 32'h00000001, 16, 1, "R4 16-bit zero fill");
      check(period_o == PW'(4*16*2), "R11 period 16-bit", 64'(period_o), 64'(4*16*2));

      // R5: 32-bit words truncated
      send_frame(32'h812345FF, 32, 32'h7EDCBA01, 32, 1, "R5 32-bit truncation");
      send_frame(32'hFFFFFFFF, 32, 32'h000001FF, 32, 1, "R5 32-bit truncation");
      send_frame(32'h13579BDF, 32, 32'h2468ACE0, 32, 1, "R5 32-bit truncation");
      check(ready_o == 1'b1, "R8 ready kept across formats", 64'(ready_o), 64'h1);

      // R7 R9: mixed lengths in one frame
      send_frame(32'h0000ABCD, 16, 32'h00ABCDEF, 24, 1, "R7 mixed lengths");
      send_frame(32'h00111111, 24, 32'h00222222, 24, 1, "R7 after mixed");
      check(ready_o == 1'b0, "R9 malformed frame clears ready", 64'(ready_o), 64'h0);
      send_frame(32'h00333333, 24, 32'h00444444, 24, 1, "R8 recovery pair");
      send_frame(32'h00555555, 24, 32'h00666666, 24, 0, "");
      check(ready_o == 1'b1, "R8 ready regained", 64'(ready_o), 64'h1);

      // R10: stall of word select
      bclk = 1'b0;
      repeat (500) @(negedge clk);
      check(ready_o == 1'b0, "R10 stall clears ready", 64'(ready_o), 64'h0);

      // R12: slower bit clock, first frame after stall presented (R10)
      half = 3;
      send_frame(32'h89ABCDEF, 32, 32'h01234567, 32, 1, "R10 R12 first after stall");
      send_frame(32'hDEADBEEF, 32, 32'h0BADF00D, 32, 1, "R12 ratio six");
      send_frame(32'h80000000, 32, 32'h7FFFFFFF, 32, 1, "R12 ratio six");
      check(ready_o == 1'b1, "R12 ready at ratio six", 64'(ready_o), 64'h1);
      check(period_o == PW'(4*32*3), "R11 R12 period 32-bit", 64'(period_o), 64'(4*32*3));
      send_frame(32'h00000000, 24, 32'h00000000, 24, 0, "");

      repeat (50) @(negedge clk);
      check(exp_q.size() == 0, "R6 all pairs presented", 64'(exp_q.size()), 64'h0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule